// File: doc/BRIEF.md
# Frame-Relative Data Address Resolver

This block turns the file-register operand of an 8-bit microcontroller instruction into a 12-bit data-memory address, then reads or writes a banked data RAM at that address. The address comes from four inputs: the 8-bit operand, an access-select bit, a 4-bit bank register and a 12-bit frame-pointer register. An indexed-mode enable decides how low access-bank operands are treated. With the enable clear, the access bank is a fixed window. With the enable set and the access bit at 0, operands up to the index limit (5Fh) become offsets added to the frame pointer. The core can then reach a software stack frame with short operands.

A destination bit steers each result write. When it is set, the write goes to the resolved RAM location. When it is clear, the write goes to a working register kept inside the block. The resolved address and an "indexed" flag are combinational outputs. Read data is registered and comes out one clock after the request.

Top module: `dmem_addr_unit`

## Requirements
- R1: With `idx_mode` low, `acc_sel` 0 and `opr_f` at most 5Fh, `eff_addr` is `{4'h0, opr_f}` and `indexed` is 0.
- R2: With `acc_sel` 0 and `opr_f` above 5Fh, `eff_addr` is `{4'hF, opr_f}` and `indexed` is 0. This holds whatever the value of `idx_mode`.
- R3: With `acc_sel` 1, `eff_addr` is `{bank_sel, opr_f}` and `indexed` is 0. This holds whatever the value of `idx_mode`.
- R4: With `idx_mode` high, `acc_sel` 0 and `opr_f` at most 5Fh, `eff_addr` is `frame_ptr + opr_f` and `indexed` is 1. An operand of exactly 5Fh is indexed; an operand of 60h is not.
- R5: With `frame_ptr` at 000h, indexed mode gives the same addresses as the fixed mapping for every operand.
- R6: The frame-pointer sum is taken modulo 4096 and wraps past FFFh to 000h.
- R7: A read request (`rd_en` high) at a clock edge puts the byte at `eff_addr` on `rd_data` after that edge, with `rd_valid` high. `rd_valid` is low after any edge without a request.
- R8: `wr_en` with `dest_mem` 1 stores `wr_data` at `eff_addr` on the clock edge. `wr_en` with `dest_mem` 0 leaves the RAM unchanged.
- R9: `wreg` resets to 00h. It loads `wr_data` on an edge with `wr_en` high and `dest_mem` 0, and holds its value on every other edge.
- R10: A read and a RAM write to the same address on one edge return the old byte. A later read returns the new byte.
- R11: After reset, `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| idx_mode | input | 1 | Indexed-mode enable |
| acc_sel | input | 1 | Access select: 0 access bank, 1 banked |
| opr_f | input | 8 | File-register operand |
| bank_sel | input | 4 | Bank register |
| frame_ptr | input | 12 | Frame-pointer register |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Result write request |
| dest_mem | input | 1 | Write target: 1 RAM, 0 working register |
| wr_data | input | 8 | Result byte |
| eff_addr | output | 12 | Resolved data address |
| indexed | output | 1 | High when the frame-relative mapping is in use |
| rd_data | output | 8 | Read byte, one clock after the request |
| rd_valid | output | 1 | High when `rd_data` holds a fresh read |
| wreg | output | 8 | Working register |

## Verification
The bench goes after the edge between 5Fh and 60h in both modes. A design with an off-by-one limit would index 60h, or it would send 5Fh to the special-function page. The bench checks that a frame pointer of 000h reproduces the fixed map, and that frame pointers near FFFh wrap to low addresses; a design without a proper 12-bit sum would carry into wrong pages. A write aimed at the working register is followed by a read of the same RAM location, which catches a design that also writes the RAM. A read and a write to the same address on one edge must return the old byte; forwarding the new byte would fail that check.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    // Which mapping produced the resolved address
    typedef enum logic [1:0] {
        MAP_FLAT    = 2'd0,
        MAP_SFR     = 2'd1,
        MAP_BANKED  = 2'd2,
        MAP_INDEXED = 2'd3
    } map_kind_e;

endpackage

// File: rtl/dmem_addr_resolve.sv
module dmem_addr_resolve
    import dmem_pkg::*;
#(
    parameter int            AW        = 12,
    parameter int            FW        = 8,
    parameter int            BW        = AW - FW,
    parameter logic [FW-1:0] IDX_LIMIT = 8'h5F
) (
    input  logic          idx_mode,
    input  logic          acc_sel,
    input  logic [FW-1:0] opr_f,
    input  logic [BW-1:0] bank_sel,
    input  logic [AW-1:0] frame_ptr,
    output logic [AW-1:0] addr,
    output map_kind_e     kind
);

    localparam logic [BW-1:0] PAGE_LOW = '0;
    localparam logic [BW-1:0] PAGE_SFR = '1;

    logic          low_half;
    logic [AW-1:0] f_ext;

    assign low_half = (opr_f <= IDX_LIMIT);
    assign f_ext    = {PAGE_LOW, opr_f};

    always_comb begin
        kind = MAP_FLAT;
        addr = f_ext;
        if (acc_sel) begin
            kind = MAP_BANKED;
            addr = {bank_sel, opr_f};
        end else if (!low_half) begin
            kind = MAP_SFR;
            addr = {PAGE_SFR, opr_f};
        end else if (idx_mode) begin
            kind = MAP_INDEXED;
            addr = frame_ptr + f_ext;   // wraps modulo 2**AW
        end
    end

endmodule

// File: rtl/dmem_bank_ram.sv
module dmem_bank_ram #(
    parameter int AW         = 12,
    parameter int DW         = 8,
    parameter bit READ_FIRST = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          re,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_d, rdata_q;

    generate
        if (READ_FIRST) begin : g_read_first
            always_comb begin
                rdata_d = rdata_q;
                if (re) rdata_d = mem[addr];
            end
        end else begin : g_write_first
            always_comb begin
                rdata_d = rdata_q;
                if (re) rdata_d = we ? wdata : mem[addr];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/dmem_addr_unit.sv
module dmem_addr_unit
    import dmem_pkg::*;
#(
    parameter int            AW         = 12,
    parameter int            FW         = 8,
    parameter int            DW         = 8,
    parameter int            BW         = AW - FW,
    parameter logic [FW-1:0] IDX_LIMIT  = 8'h5F,
    parameter bit            READ_FIRST = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_mode,
    input  logic          acc_sel,
    input  logic [FW-1:0] opr_f,
    input  logic [BW-1:0] bank_sel,
    input  logic [AW-1:0] frame_ptr,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic          dest_mem,
    input  logic [DW-1:0] wr_data,
    output logic [AW-1:0] eff_addr,
    output logic          indexed,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic [DW-1:0] wreg
);

    typedef struct packed {
        logic          rd_valid;
        logic [DW-1:0] wreg;
    } state_t;

    state_t    st_d, st_q;
    map_kind_e kind;
    logic      ram_we;

    dmem_addr_resolve #(
        .AW(AW), .FW(FW), .BW(BW), .IDX_LIMIT(IDX_LIMIT)
    ) i_resolve (
        .idx_mode (idx_mode),
        .acc_sel  (acc_sel),
        .opr_f    (opr_f),
        .bank_sel (bank_sel),
        .frame_ptr(frame_ptr),
        .addr     (eff_addr),
        .kind     (kind)
    );

    assign ram_we = wr_en && dest_mem;

    dmem_bank_ram #(
        .AW(AW), .DW(DW), .READ_FIRST(READ_FIRST)
    ) i_ram (
        .clk  (clk),
        .rst_n(rst_n),
        .re   (rd_en),
        .we   (ram_we),
        .addr (eff_addr),
        .wdata(wr_data),
        .rdata(rd_data)
    );

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = rd_en;
        if (wr_en && !dest_mem) st_d.wreg = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign indexed  = (kind == MAP_INDEXED);
    assign rd_valid = st_q.rd_valid;
    assign wreg     = st_q.wreg;

endmodule

// File: rtl/dmem_addr_unit_chk.sv
module dmem_addr_unit_chk #(
    parameter int            AW        = 12,
    parameter int            FW        = 8,
    parameter int            DW        = 8,
    parameter int            BW        = AW - FW,
    parameter logic [FW-1:0] IDX_LIMIT = 8'h5F
) (
    input logic          clk,
    input logic          rst_n,
    input logic          idx_mode,
    input logic          acc_sel,
    input logic [FW-1:0] opr_f,
    input logic [BW-1:0] bank_sel,
    input logic [AW-1:0] eff_addr,
    input logic          indexed,
    input logic          rd_en,
    input logic          wr_en,
    input logic          dest_mem,
    input logic [DW-1:0] wr_data,
    input logic          rd_valid,
    input logic [DW-1:0] wreg
);

    p_flat_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!idx_mode && !acc_sel && opr_f <= IDX_LIMIT) |-> (eff_addr[AW-1:FW] == '0 && !indexed));

    p_sfr_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_sel && opr_f > IDX_LIMIT) |-> (eff_addr[AW-1:FW] == '1 && !indexed));

    p_bank_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_sel |-> (eff_addr[AW-1:FW] == bank_sel && eff_addr[FW-1:0] == opr_f && !indexed));

    p_index_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        indexed |-> (idx_mode && !acc_sel && opr_f <= IDX_LIMIT));

    p_rd_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    p_rd_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    p_wreg_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !dest_mem) |=> (wreg == $past(wr_data)));

    p_wreg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !dest_mem) |=> $stable(wreg));

endmodule

bind dmem_addr_unit dmem_addr_unit_chk #(
    .AW(AW), .FW(FW), .DW(DW), .BW(BW), .IDX_LIMIT(IDX_LIMIT)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx_mode(idx_mode),
    .acc_sel (acc_sel),
    .opr_f   (opr_f),
    .bank_sel(bank_sel),
    .eff_addr(eff_addr),
    .indexed (indexed),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .dest_mem(dest_mem),
    .wr_data (wr_data),
    .rd_valid(rd_valid),
    .wreg    (wreg)
);

// File: tb/test_dmem_addr_unit.sv
module test_dmem_addr_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        idx_mode, acc_sel, rd_en, wr_en, dest_mem;
    logic [7:0]  opr_f, wr_data;
    logic [3:0]  bank_sel;
    logic [11:0] frame_ptr;
    logic [11:0] eff_addr;
    logic        indexed, rd_valid;
    logic [7:0]  rd_data, wreg;

    always #10 clk = ~clk;

    dmem_addr_unit i_dmem_addr_unit (
        .clk(clk), .rst_n(rst_n), .idx_mode(idx_mode), .acc_sel(acc_sel),
        .opr_f(opr_f), .bank_sel(bank_sel), .frame_ptr(frame_ptr),
        .rd_en(rd_en), .wr_en(wr_en), .dest_mem(dest_mem), .wr_data(wr_data),
        .eff_addr(eff_addr), .indexed(indexed), .rd_data(rd_data),
        .rd_valid(rd_valid), .wreg(wreg)
    );

    int         n_chk  = 0;
    int         n_fail = 0;
    bit         done   = 1'b0;
    logic [7:0] mdl [4096];
    logic [7:0] w_mdl = 8'h00;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] ref_addr(input logic e, input logic a, input logic [7:0] f,
                                             input logic [3:0] bs, input logic [11:0] fp);
        if (a)          return {bs, f};
        if (f > 8'h5F)  return {4'hF, f};
        if (e)          return fp + {4'h0, f};
        return {4'h0, f};
    endfunction

    function automatic logic [7:0] pat(input logic [11:0] ad);
        return ad[7:0] ^ {ad[11:8], ad[11:8]} ^ 8'h5A;
    endfunction

    task automatic step(input logic e, input logic a, input logic [7:0] f, input logic [3:0] bs,
                        input logic [11:0] fp, input logic rd, input logic wr, input logic dm,
                        input logic [7:0] wd, input string tag);
        logic [11:0] ea;
        @(negedge clk);
        idx_mode = e; acc_sel = a; opr_f = f; bank_sel = bs; frame_ptr = fp;
        rd_en = rd; wr_en = wr; dest_mem = dm; wr_data = wd;
        #1;
        ea = ref_addr(e, a, f, bs, fp);
        check(eff_addr == ea, {tag, " addr"}, eff_addr, ea);
        check(indexed == (e && !a && f <= 8'h5F), {"R4 indexed flag / ", tag}, indexed,
              (e && !a && f <= 8'h5F));
        if (rd) begin
            exp_q.push_back(mdl[ea]);
            tag_q.push_back(tag);
        end
        if (wr && dm)  mdl[ea] = wd;
        if (wr && !dm) w_mdl   = wd;
    endtask

    task automatic idle();
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic check_w(input string tag);
        @(posedge clk);
        #2;
        check(wreg == w_mdl, tag, wreg, w_mdl);
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            logic req;
            @(posedge clk);
            req = rd_en;
            #2;
            if (rst_n && (req || rd_valid)) begin
                check(rd_valid == req, "R7 rd_valid follows request", rd_valid, req);
                if (req && exp_q.size() > 0) begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(rd_data == e, {t, " data"}, rd_data, e);
                end
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; idx_mode = 1'b0; acc_sel = 1'b0; opr_f = '0; bank_sel = '0;
        frame_ptr = '0; rd_en = 1'b0; wr_en = 1'b0; dest_mem = 1'b0; wr_data = '0;
        repeat (3) @(posedge clk);
        #2;
        check(rd_valid == 1'b0, "R11 reset rd_valid", rd_valid, 0);
        check(wreg == 8'h00, "R9 reset wreg", wreg, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: fill every location through banked addressing
        for (int b = 0; b < 16; b++)
            for (int f = 0; f < 256; f++)
                step(b[0], 1'b1, f[7:0], b[3:0], 12'h000, 1'b0, 1'b1, 1'b1,
                     pat({b[3:0], f[7:0]}), "R3 banked fill");
        idle();

        // R3 reads in both modes
        step(1'b0, 1'b1, 8'h12, 4'h7, 12'h300, 1'b1, 1'b0, 1'b0, 8'h00, "R3 banked read");
        step(1'b1, 1'b1, 8'h05, 4'h2, 12'h300, 1'b1, 1'b0, 1'b0, 8'h00, "R3 banked ext read");
        // R1 fixed low window
        step(1'b0, 1'b0, 8'h00, 4'h9, 12'h300, 1'b1, 1'b0, 1'b0, 8'h00, "R1 flat 00");
        step(1'b0, 1'b0, 8'h2A, 4'h9, 12'h300, 1'b1, 1'b0, 1'b0, 8'h00, "R1 flat 2A");
        step(1'b0, 1'b0, 8'h5F, 4'h9, 12'h300, 1'b1, 1'b0, 1'b0, 8'h00, "R1 flat 5F");
        // R2 special page, both modes
        step(1'b0, 1'b0, 8'h60, 4'h9, 12'h300, 1'b1, 1'b0, 1'b0, 8'h00, "R2 sfr 60");
        step(1'b1, 1'b0, 8'h60, 4'h9, 12'h300, 1'b1, 1'b0, 1'b0, 8'h00, "R2 R4 sfr 60 ext");
        step(1'b1, 1'b0, 8'hFF, 4'h9, 12'h300, 1'b1, 1'b0, 1'b0, 8'h00, "R2 sfr FF ext");
        step(1'b0, 1'b0, 8'h80, 4'h9, 12'h300, 1'b1, 1'b0, 1'b0, 8'h00, "R2 sfr 80");
        // R4 frame-relative
        step(1'b1, 1'b0, 8'h00, 4'h9, 12'h345, 1'b1, 1'b0, 1'b0, 8'h00, "R4 index 00");
        step(1'b1, 1'b0, 8'h10, 4'h9, 12'h345, 1'b1, 1'b0, 1'b0, 8'h00, "R4 index 10");
        step(1'b1, 1'b0, 8'h5F, 4'h9, 12'h345, 1'b1, 1'b0, 1'b0, 8'h00, "R4 index 5F");
        // R5 zero frame pointer
        step(1'b1, 1'b0, 8'h00, 4'h3, 12'h000, 1'b1, 1'b0, 1'b0, 8'h00, "R5 zero fp 00");
        step(1'b1, 1'b0, 8'h33, 4'h3, 12'h000, 1'b1, 1'b0, 1'b0, 8'h00, "R5 zero fp 33");
        step(1'b1, 1'b0, 8'h5F, 4'h3, 12'h000, 1'b1, 1'b0, 1'b0, 8'h00, "R5 zero fp 5F");
        // R6 wrap
        step(1'b1, 1'b0, 8'h5F, 4'h3, 12'hFF0, 1'b1, 1'b0, 1'b0, 8'h00, "R6 wrap to 04F");
        step(1'b1, 1'b0, 8'h01, 4'h3, 12'hFFF, 1'b1, 1'b0, 1'b0, 8'h00, "R6 wrap to 000");
        idle();

        // R8 write through indexed mapping, read back through banked
        step(1'b1, 1'b0, 8'h20, 4'h0, 12'h5E8, 1'b0, 1'b1, 1'b1, 8'hC3, "R8 indexed write");
        step(1'b0, 1'b1, 8'h08, 4'h6, 12'h000, 1'b1, 1'b0, 1'b0, 8'h00, "R8 readback 608");
        // R8/R9 write to working register leaves RAM alone
        step(1'b0, 1'b0, 8'h44, 4'h0, 12'h000, 1'b0, 1'b1, 1'b0, 8'h9D, "R9 wreg load");
        check_w("R9 wreg loaded");
        step(1'b0, 1'b0, 8'h44, 4'h0, 12'h000, 1'b1, 1'b0, 1'b0, 8'h00, "R8 ram untouched 044");
        step(1'b0, 1'b0, 8'h45, 4'h0, 12'h000, 1'b0, 1'b1, 1'b1, 8'h71, "R9 ram write");
        check_w("R9 wreg held on ram write");
        idle();
        check_w("R9 wreg held idle");
        // R10 same-edge read and write
        step(1'b0, 1'b1, 8'hA0, 4'hB, 12'h000, 1'b1, 1'b1, 1'b1, 8'hE7, "R10 read old");
        step(1'b0, 1'b1, 8'hA0, 4'hB, 12'h000, 1'b1, 1'b0, 1'b0, 8'h00, "R10 read new");
        idle();
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R7 all reads returned", exp_q.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule